// File: doc/BRIEF.md
# Per-Word Formatted SPI Master

This block is a serial peripheral interface master that moves one character of 2 to 16 bits per request. A host hands over a data word together with a 2-bit format index and a chip-select number on a valid/ready port. The format index picks one of four format entries that sit on a static configuration input. Each entry sets the clock divider, character length, idle clock level, clock phase, parity, bit order, and chip-select lead and lag times. Consecutive words may therefore use entirely different formats and different targets.

For each word the block pulls the chosen active-low select line low, waits out the lead time and toggles SCLK for the data bits plus an optional parity bit. It shifts MOSI out and captures MISO. It then waits out the lag time and releases the select line. In the same cycle the select line goes high, the captured word is presented for a single cycle with a parity-error flag. The half period of SCLK is `prescale + 1` module clocks, so the serial clock runs at f_clk / (2 × (prescale + 1)).

Top module: `spi_fmtword_master`

## Requirements
- R1: After reset all chip-select outputs are high, SCLK is 0, `rx_valid_o` is 0 and `tx_ready_o` is 1.
- R2: During a word only the select line numbered by `tx_cs_i` is low, and at most one line is ever low. A number of 6 or more asserts no line.
- R3: When a word is accepted, SCLK moves to the entry's idle level (bit 11, 1 = idles high). After the word, SCLK is back at that level.
- R4: Each SCLK half period lasts `prescale + 1` clocks. The prescaler is 11 bits wide (entry bits 26:16).
- R5: From the select line falling to the first SCLK edge there are `lead + prescale + 2` clocks (lead in entry bits 7:4).
- R6: From the last SCLK edge to the select line rising there are `lag + 1` clocks (lag in entry bits 3:0). `rx_valid_o` is high for exactly that one cycle, in which all select lines are already high.
- R7: The entry's order bit (bit 8) picks the shift order: 0 sends and receives the most significant bit first, 1 the least significant bit first.
- R8: With phase bit 10 = 0, MOSI changes on odd-numbered (leading) edges and both sides sample on even (trailing) edges. With phase = 1, the first bit is on MOSI from select assertion, MOSI changes on trailing edges, and sampling is on leading edges.
- R9: The length is `len_field + 1` bits (entry bits 15:12, a field of 0 means 2 bits). The received bits are right-justified in `rx_data_o` and the bits above the length read 0.
- R10: With parity bit 9 set, one extra bit is sent after the data so that data plus parity has even weight. The received extra bit is checked the same way; a mismatch sets `rx_perr_o` but the word still completes.
- R11: Entry k occupies `fmt_table_i[27*k +: 27]`, and `tx_fmt_i` selects the entry for each word independently.
- R12: `tx_ready_o` is low from acceptance until the result cycle, and a request is taken only when valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_table_i | input | 108 | Four packed 27-bit format entries |
| tx_valid_i | input | 1 | Host offers a word |
| tx_ready_o | output | 1 | Block can take a word |
| tx_data_i | input | 16 | Word to send, right-justified |
| tx_fmt_i | input | 2 | Format entry index |
| tx_cs_i | input | 3 | Chip-select number |
| rx_valid_o | output | 1 | One-cycle strobe for the received word |
| rx_data_o | output | 16 | Received word, right-justified |
| rx_perr_o | output | 1 | Received parity did not match |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 6 | Active-low chip selects |

## Verification
A wrong bit index or order shows as a MOSI mismatch at the peripheral's sampling edge within the same word. A wrong capture shows in `rx_data_o` at the end of that word. A miscounted divider or lead/lag counter shifts the measured gap between select and SCLK edges on the first word that uses the affected format. A stale or wrongly latched format entry shows at once on the following word, because the bench changes format, target line and polarity from one word to the next and checks the idle level, select line and parity flag of every word.

// File: rtl/spi_fw_pkg.sv
`timescale 1ns/1ps
package spi_fw_pkg;
    localparam int PRE_W  = 11;
    localparam int LEN_W  = 4;
    localparam int CSD_W  = 4;
    localparam int DATA_W = 1 << LEN_W;
    localparam int CNT_W  = LEN_W + 1;
    localparam int EDGE_W = LEN_W + 2;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [LEN_W-1:0] len_m1;
        logic             cpol;
        logic             phase;
        logic             par_en;
        logic             lsb_first;
        logic [CSD_W-1:0] lead;
        logic [CSD_W-1:0] lag;
    } fmt_t;

    localparam int FMT_W = $bits(fmt_t);

    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD} st_e;

    function automatic logic [CNT_W-1:0] len_of(input fmt_t f);
        if (f.len_m1 == '0) return CNT_W'(2);
        return CNT_W'(f.len_m1) + CNT_W'(1);
    endfunction
endpackage

// File: rtl/spi_fw_fmt_pick.sv
`timescale 1ns/1ps
module spi_fw_fmt_pick
    import spi_fw_pkg::*;
#(
    parameter int NUM_FMT = 4,
    localparam int SEL_W = $clog2(NUM_FMT)
) (
    input  logic [NUM_FMT*FMT_W-1:0] table_i,
    input  logic [SEL_W-1:0]         sel_i,
    output fmt_t                     fmt_o
);
    logic [FMT_W-1:0] entry [NUM_FMT];

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_entry
        assign entry[g] = table_i[g*FMT_W +: FMT_W];
    end

    assign fmt_o = fmt_t'(entry[sel_i]);
endmodule

// File: rtl/spi_fw_bit_pick.sv
`timescale 1ns/1ps
module spi_fw_bit_pick
    import spi_fw_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic              lsb_i,
    input  logic [CNT_W-1:0]  idx_i,
    output logic              bit_o
);
    logic [CNT_W-1:0] pos;
    logic             par;

    always_comb begin
        par = 1'b0;
        for (int k = 0; k < DATA_W; k++) begin
            if (CNT_W'(k) < len_i) par = par ^ data_i[k];
        end
        pos = lsb_i ? idx_i : (len_i - CNT_W'(1) - idx_i);
        bit_o = par;
        if (idx_i < len_i) begin
            bit_o = 1'b0;
            for (int k = 0; k < DATA_W; k++) begin
                if (CNT_W'(k) == pos) bit_o = data_i[k];
            end
        end
    end
endmodule

// File: rtl/spi_fmtword_master.sv
`timescale 1ns/1ps
module spi_fmtword_master
    import spi_fw_pkg::*;
#(
    parameter int NUM_CS  = 6,
    parameter int NUM_FMT = 4,
    localparam int SEL_W = $clog2(NUM_FMT),
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_FMT*FMT_W-1:0] fmt_table_i,
    input  logic                     tx_valid_i,
    output logic                     tx_ready_o,
    input  logic [DATA_W-1:0]        tx_data_i,
    input  logic [SEL_W-1:0]         tx_fmt_i,
    input  logic [CS_W-1:0]          tx_cs_i,
    output logic                     rx_valid_o,
    output logic [DATA_W-1:0]        rx_data_o,
    output logic                     rx_perr_o,
    output logic                     sclk_o,
    output logic                     mosi_o,
    input  logic                     miso_i,
    output logic [NUM_CS-1:0]        cs_n_o
);
    typedef struct packed {
        st_e               st;
        fmt_t              fmt;
        logic [DATA_W-1:0] data;
        logic [NUM_CS-1:0] cs_n;
        logic [CSD_W-1:0]  cnt;
        logic [PRE_W-1:0]  div;
        logic [EDGE_W-1:0] edg;
        logic [CNT_W-1:0]  tx_idx;
        logic [CNT_W-1:0]  rx_idx;
        logic [DATA_W-1:0] rx_shift;
        logic              rxpar;
        logic              perr;
        logic              sclk;
        logic              mosi;
        logic              rx_valid;
    } reg_t;

    reg_t reg_d, reg_q;

    fmt_t              new_fmt;
    fmt_t              use_fmt;
    logic              idle_w;
    logic [CNT_W-1:0]  use_len;
    logic [CNT_W-1:0]  q_len;
    logic [CNT_W-1:0]  q_bits;
    logic [EDGE_W-1:0] q_edges;
    logic [EDGE_W-1:0] edge_nx;
    logic              pick_bit;
    logic              lead_w;
    logic              do_drive;
    logic              do_sample;
    logic [NUM_CS-1:0] sel_hot;

    spi_fw_fmt_pick #(.NUM_FMT(NUM_FMT)) u_fmt_pick (
        .table_i (fmt_table_i),
        .sel_i   (tx_fmt_i),
        .fmt_o   (new_fmt)
    );

    assign idle_w  = (reg_q.st == ST_IDLE);
    assign use_fmt = idle_w ? new_fmt : reg_q.fmt;
    assign use_len = len_of(use_fmt);

    spi_fw_bit_pick u_bit_pick (
        .data_i (idle_w ? tx_data_i : reg_q.data),
        .len_i  (use_len),
        .lsb_i  (use_fmt.lsb_first),
        .idx_i  (idle_w ? '0 : reg_q.tx_idx),
        .bit_o  (pick_bit)
    );

    assign q_len   = len_of(reg_q.fmt);
    assign q_bits  = q_len + CNT_W'(reg_q.fmt.par_en);
    assign q_edges = EDGE_W'(q_bits) << 1;
    assign edge_nx = reg_q.edg + EDGE_W'(1);
    assign lead_w  = edge_nx[0];
    assign do_drive  = reg_q.fmt.phase ? (!lead_w && (reg_q.tx_idx < q_bits)) : lead_w;
    assign do_sample = reg_q.fmt.phase ? lead_w : !lead_w;
    assign sel_hot   = NUM_CS'(1) << tx_cs_i;

    always_comb begin
        reg_d = reg_q;
        reg_d.rx_valid = 1'b0;
        unique case (reg_q.st)
            ST_IDLE: begin
                if (tx_valid_i) begin
                    reg_d.st       = ST_SETUP;
                    reg_d.fmt      = new_fmt;
                    reg_d.data     = tx_data_i;
                    reg_d.cs_n     = ~sel_hot;
                    reg_d.cnt      = new_fmt.lead;
                    reg_d.sclk     = new_fmt.cpol;
                    reg_d.mosi     = new_fmt.phase ? pick_bit : 1'b0;
                    reg_d.tx_idx   = new_fmt.phase ? CNT_W'(1) : '0;
                    reg_d.rx_idx   = '0;
                    reg_d.edg      = '0;
                    reg_d.div      = '0;
                    reg_d.rx_shift = '0;
                    reg_d.rxpar    = 1'b0;
                    reg_d.perr     = 1'b0;
                end
            end
            ST_SETUP: begin
                if (reg_q.cnt == '0) begin
                    reg_d.st  = ST_SHIFT;
                    reg_d.div = '0;
                end else begin
                    reg_d.cnt = reg_q.cnt - CSD_W'(1);
                end
            end
            ST_SHIFT: begin
                if (reg_q.div == reg_q.fmt.pre) begin
                    reg_d.div  = '0;
                    reg_d.sclk = ~reg_q.sclk;
                    reg_d.edg  = edge_nx;
                    if (do_drive) begin
                        reg_d.mosi   = pick_bit;
                        reg_d.tx_idx = reg_q.tx_idx + CNT_W'(1);
                    end
                    if (do_sample) begin
                        reg_d.rx_idx = reg_q.rx_idx + CNT_W'(1);
                        if (reg_q.rx_idx < q_len) begin
                            reg_d.rxpar = reg_q.rxpar ^ miso_i;
                            if (reg_q.fmt.lsb_first) begin
                                for (int k = 0; k < DATA_W; k++) begin
                                    if (CNT_W'(k) == reg_q.rx_idx) reg_d.rx_shift[k] = miso_i;
                                end
                            end else begin
                                reg_d.rx_shift = {reg_q.rx_shift[DATA_W-2:0], miso_i};
                            end
                        end else begin
                            reg_d.perr = reg_q.rxpar ^ miso_i;
                        end
                    end
                    if (edge_nx == q_edges) begin
                        reg_d.st  = ST_HOLD;
                        reg_d.cnt = reg_q.fmt.lag;
                    end
                end else begin
                    reg_d.div = reg_q.div + PRE_W'(1);
                end
            end
            ST_HOLD: begin
                if (reg_q.cnt == '0) begin
                    reg_d.st       = ST_IDLE;
                    reg_d.cs_n     = '1;
                    reg_d.rx_valid = 1'b1;
                end else begin
                    reg_d.cnt = reg_q.cnt - CSD_W'(1);
                end
            end
            default: reg_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            reg_q      <= '0;
            reg_q.st   <= ST_IDLE;
            reg_q.cs_n <= '1;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign tx_ready_o = idle_w;
    assign rx_valid_o = reg_q.rx_valid;
    assign rx_data_o  = reg_q.rx_shift;
    assign rx_perr_o  = reg_q.perr;
    assign sclk_o     = reg_q.sclk;
    assign mosi_o     = reg_q.mosi;
    assign cs_n_o     = reg_q.cs_n;

    p_cs_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~cs_n_o));
    p_ready_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_ready_o |-> (&cs_n_o));
    p_rx_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |=> !rx_valid_o);
    p_rx_csoff_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |-> (&cs_n_o));
    p_sclk_rest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |-> (sclk_o == reg_q.fmt.cpol));
    p_rx_just_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |-> ((rx_data_o >> q_len) == '0));
    p_sclk_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_q.st == ST_SHIFT && reg_q.div != reg_q.fmt.pre) |=> $stable(sclk_o));
endmodule

// File: tb/spi_fmtword_master_tb_top.sv
`timescale 1ns/1ps
module spi_fmtword_master_tb_top;
    import spi_fw_pkg::*;

    typedef struct {
        int pre; int len; int cpol; int ph; int par; int lsb; int su; int ho;
        logic [15:0] tx; logic [15:0] mi; logic bad; int cs;
    } word_t;
    typedef struct { logic [15:0] rx; logic perr; } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [4*FMT_W-1:0] ftab;
    logic tx_valid = 1'b0, tx_ready;
    logic [15:0] tx_data = '0;
    logic [1:0] tx_fmt = '0;
    logic [2:0] tx_cs = '0;
    logic rx_valid, rx_perr, sclk, mosi, miso = 1'b0;
    logic [15:0] rx_data;
    logic [5:0] cs_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int f_pre[4], f_len[4], f_cpol[4], f_ph[4], f_par[4], f_lsb[4], f_su[4], f_ho[4];
    word_t sq[$];
    exp_t  eq[$];

    always #5 clk = ~clk;  // 100 MHz

    spi_fmtword_master dut_i (
        .clk_i(clk), .rst_ni(rst_n), .fmt_table_i(ftab),
        .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
        .tx_fmt_i(tx_fmt), .tx_cs_i(tx_cs), .rx_valid_o(rx_valid),
        .rx_data_o(rx_data), .rx_perr_o(rx_perr), .sclk_o(sclk),
        .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic bbit(logic [15:0] w, int len, int lsb, int idx, logic flip);
        logic p = 1'b0;
        if (idx < len) return (lsb != 0) ? w[idx] : w[len-1-idx];
        for (int k = 0; k < len; k++) p ^= w[k];
        return p ^ flip;
    endfunction

    task automatic set_fmt(input int i, input int pre, input int len, input int cpol,
                           input int ph, input int par, input int lsb, input int su, input int ho);
        fmt_t f;
        f_pre[i] = pre; f_len[i] = len; f_cpol[i] = cpol; f_ph[i] = ph;
        f_par[i] = par; f_lsb[i] = lsb; f_su[i] = su; f_ho[i] = ho;
        f.pre = PRE_W'(pre); f.len_m1 = LEN_W'(len - 1); f.cpol = cpol[0]; f.phase = ph[0];
        f.par_en = par[0]; f.lsb_first = lsb[0]; f.lead = CSD_W'(su); f.lag = CSD_W'(ho);
        ftab[i*FMT_W +: FMT_W] = f;
    endtask

    task automatic send(input int fi, input int cs, input logic [15:0] d,
                        input logic [15:0] mi, input logic bad);
        word_t w;
        exp_t e;
        logic [15:0] m = 16'hFFFF >> (16 - f_len[fi]);
        w.pre = f_pre[fi]; w.len = f_len[fi]; w.cpol = f_cpol[fi]; w.ph = f_ph[fi];
        w.par = f_par[fi]; w.lsb = f_lsb[fi]; w.su = f_su[fi]; w.ho = f_ho[fi];
        w.tx = d; w.mi = mi; w.bad = bad; w.cs = cs;
        e.rx = mi & m; e.perr = bad;
        sq.push_back(w);
        eq.push_back(e);
        do @(negedge clk); while (!tx_ready);
        tx_valid = 1'b1; tx_data = d; tx_fmt = 2'(fi); tx_cs = 3'(cs);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // peripheral model: drives MISO and samples MOSI
    initial begin
        forever begin
            word_t w;
            time t0, tprev, tnow;
            int nb, txi, rxi, badb;
            wait (rst_n && cs_n != 6'h3F);
            #1;
            t0 = $time - 1;
            w = sq.pop_front();
            check(cs_n == ~(6'(1) << w.cs), "R2 select line", int'(cs_n), int'(~(6'(1) << w.cs)));
            check(tx_ready == 1'b0, "R12 ready busy", int'(tx_ready), 0);
            check(sclk == w.cpol[0], "R3 idle level at start", int'(sclk), w.cpol);
            nb = w.len + w.par; txi = 0; rxi = 0; badb = 0; tprev = t0;
            if (w.ph != 0) begin
                miso = bbit(w.mi, w.len, w.lsb, 0, w.bad);
                txi = 1;
                check(mosi == bbit(w.tx, w.len, w.lsb, 0, 1'b0), "R8 early first bit",
                      int'(mosi), int'(bbit(w.tx, w.len, w.lsb, 0, 1'b0)));
            end
            for (int e = 1; e <= 2*nb; e++) begin
                bit lead;
                @(sclk);
                tnow = $time;
                if (e == 1) check((tnow - t0)/10 == w.su + w.pre + 2, "R5 lead gap",
                                  int'((tnow - t0)/10), w.su + w.pre + 2);
                if (e == 2) check((tnow - tprev)/10 == w.pre + 1, "R4 half period",
                                  int'((tnow - tprev)/10), w.pre + 1);
                tprev = tnow;
                lead = (e % 2) == 1;
                if ((w.ph == 0) ? !lead : lead) begin
                    if (mosi !== bbit(w.tx, w.len, w.lsb, rxi, 1'b0)) badb++;
                    rxi++;
                end
                if ((w.ph == 0) ? lead : (!lead && txi < nb)) begin
                    #1 miso = bbit(w.mi, w.len, w.lsb, txi, w.bad);
                    txi++;
                end
            end
            check(badb == 0, "R7/R8/R10 MOSI bit stream", badb, 0);
            wait (cs_n == 6'h3F);
            check(($time - tprev)/10 == w.ho + 1, "R6 lag gap",
                  int'(($time - tprev)/10), w.ho + 1);
            check(sclk == w.cpol[0], "R3 idle level at end", int'(sclk), w.cpol);
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            exp_t e;
            if (eq.size() == 0) begin
                check(1'b0, "R6 unexpected result", 1, 0);
            end else begin
                e = eq.pop_front();
                check(rx_data == e.rx, "R9 received word", int'(rx_data), int'(e.rx));
                check(rx_perr == e.perr, "R10 parity flag", int'(rx_perr), int'(e.perr));
                check(&cs_n, "R6 select released at result", int'(cs_n), 63);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R12 watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        ftab = '0;
        set_fmt(0, 0, 8, 0, 0, 0, 0, 0, 0);
        set_fmt(1, 3, 16, 1, 1, 1, 1, 2, 3);
        set_fmt(2, 1, 2, 0, 1, 1, 0, 5, 1);
        set_fmt(3, 2, 11, 1, 0, 0, 1, 1, 0);
        repeat (3) @(negedge clk);
        check(cs_n == 6'h3F, "R1 selects high", int'(cs_n), 63);
        check(sclk == 1'b0, "R1 sclk low", int'(sclk), 0);
        check(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);
        check(rx_valid == 1'b0, "R1 no result", int'(rx_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: formats change word to word
        send(0, 0, 16'h00A5, 16'h003C, 1'b0);
        send(1, 5, 16'h1234, 16'hBEEF, 1'b0);
        send(2, 2, 16'h0002, 16'h0001, 1'b0);
        send(3, 3, 16'h05A3, 16'h06D1, 1'b0);
        send(1, 1, 16'hFFFF, 16'h0001, 1'b1);
        send(2, 4, 16'h0001, 16'h0002, 1'b1);
        send(0, 0, 16'h0000, 16'h00FF, 1'b0);
        send(3, 5, 16'h07FF, 16'h0000, 1'b0);
        wait (eq.size() == 0 && sq.size() == 0);
        repeat (5) @(negedge clk);
        check(tx_ready == 1'b1 && cs_n == 6'h3F, "R12 idle after run", int'(tx_ready), 1);
        finish_run();
    end
endmodule